// File: doc/BRIEF.md
# Latched Event Status Register with Interrupt Request

This block gathers up to sixteen event signals into one status word. Software can read that word in two views. The real-time view shows the present level of each event. The latched view holds a sticky record of event edges. Each bit is configured on its own through a per-bit mode vector:

- A rising-type bit records only the onset of its event.
- A change-type bit records both the onset and the end of its event.

After a latched bit has been cleared, it stays clear while its event remains high. The event must first go away and then return before the bit can set again.

A select input picks the clearing method. In clear-on-read mode, reading the latched view clears it. With a 16-bit bus the whole word is cleared; in 8-bit bus mode only the byte lanes that were read are cleared. In clear-on-write mode, writing a 1 to a bit clears that bit. A per-bit enable word masks the latched bits, and the OR of the unmasked bits drives a registered interrupt request.

Top module: `latched_status_reg`

## Requirements
- R1: A read with `rd_rt`=1 returns the present level of `evt_in` in `rd_data` one cycle later. It clears no latched bit.
- R2: A rising-type bit (`chg_mode` bit 0) sets on a 0-to-1 transition of its event. It then stays set until it is cleared, and a 1-to-0 transition leaves it as it is.
- R3: A latched bit that was cleared while its event stays high does not set again until the event falls and rises again.
- R4: A change-type bit (`chg_mode` bit 1) sets on both the 0-to-1 and the 1-to-0 transition of its event.
- R5: With `clr_wr`=0 and `bus8`=0, a read of the latched view (`rd_rt`=0) returns all 16 latched bits one cycle later, whatever `byte_en` holds, and clears all 16 bits.
- R6: With `clr_wr`=0 and `bus8`=1, a latched read returns only the lanes whose `byte_en` bit is 1 (bit 0 selects bits 7:0, bit 1 selects bits 15:8). The other lanes read as 0. Only the lanes that were read are cleared.
- R7: With `clr_wr`=1, a write clears each latched bit where `wr_data` holds 1 and the lane's `byte_en` bit is 1. Bits written with 0 are unchanged, and reads clear nothing. With `clr_wr`=0, writes have no effect.
- R8: If an event transition and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: `irq` is 1 in the cycle after any bit is set in both the latched word and `irq_en`, and 0 otherwise.
- R10: Reset forces the latched word, `rd_data` and `irq` to 0, and takes every event's previous level as 0. An event that is high when reset ends therefore latches on the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 16 | Event levels |
| chg_mode | input | 16 | Per-bit type: 1 change-type, 0 rising-type |
| bus8 | input | 1 | 1 selects 8-bit bus mode for clear-on-read |
| clr_wr | input | 1 | 1 clear-on-write-one, 0 clear-on-read |
| rd_en | input | 1 | Read strobe |
| rd_rt | input | 1 | Read view: 1 real-time, 0 latched |
| wr_en | input | 1 | Write strobe |
| byte_en | input | 2 | Byte-lane enables |
| wr_data | input | 16 | Write data (1 clears in clear-on-write mode) |
| irq_en | input | 16 | Per-bit interrupt enable |
| rd_data | output | 16 | Registered read data, 0 when no read took place |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default of two byte lanes, so the register is 16 bits wide. This width makes both lane-select paths reachable. The bench can observe a read of the low lane alone, a read of the high lane alone, and a read of both. These are exactly the cases in which the 8-bit clear-on-read rule differs from the 16-bit rule. The bench sets the upper lane to change-type and the lower lane to rising-type, so one event pattern exercises both latch types side by side.

// File: rtl/latched_status_reg.sv
module latched_status_reg #(
  parameter int NBYTES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBYTES*8-1:0] evt_in,
  input  logic [NBYTES*8-1:0] chg_mode,
  input  logic                bus8,
  input  logic                clr_wr,
  input  logic                rd_en,
  input  logic                rd_rt,
  input  logic                wr_en,
  input  logic [NBYTES-1:0]   byte_en,
  input  logic [NBYTES*8-1:0] wr_data,
  input  logic [NBYTES*8-1:0] irq_en,
  output logic [NBYTES*8-1:0] rd_data,
  output logic                irq
);
  localparam int W = NBYTES * 8;

  logic [W-1:0] evt_q, lat, lane_m, rd_m, set_v, clr_v;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_m[b*8 +: 8] = {8{byte_en[b]}};
  end

  assign rd_m  = bus8 ? lane_m : '1;
  assign set_v = (evt_in & ~evt_q) | (chg_mode & ~evt_in & evt_q);
  assign clr_v = ((rd_en && !rd_rt && !clr_wr) ? rd_m : '0)
               | ((wr_en && clr_wr) ? (wr_data & lane_m) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q   <= '0;
      lat     <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      evt_q   <= evt_in;
      lat     <= (lat & ~clr_v) | set_v;
      rd_data <= rd_en ? ((rd_rt ? evt_in : lat) & rd_m) : '0;
      irq     <= |(lat & irq_en);
    end
  end

  a_r3_no_set_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> ((lat & ~$past(lat) & ~($past(evt_in) ^ $past(evt_q))) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (($past(set_v) & ~lat) == '0));

  a_r2_hold_unless_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    1 |=> (($past(lat) & ~lat & ~$past(clr_v)) == '0));

  a_r1_rt_read_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_rt && !wr_en) |=> (($past(lat) & ~lat) == '0));

  a_r5_cor16_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_rt && !clr_wr && !bus8) |=> ((lat & ~$past(set_v)) == '0));

  a_r9_irq_needs_enabled_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(lat & irq_en) != '0));
endmodule

// File: tb/tb_latched_status_reg.sv
module tb_latched_status_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] evt_in = '0, chg_mode = 16'hFF00, wr_data = '0, irq_en = '0;
  logic bus8 = 1'b0, clr_wr = 1'b1, rd_en = 1'b0, rd_rt = 1'b0, wr_en = 1'b0;
  logic [1:0] byte_en = 2'b11;
  logic [15:0] rd_data;
  logic irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  latched_status_reg dut (.*);

  // {event, clear-write data, expected latched word}; upper lane change-type, COW mode
  localparam logic [47:0] VEC [12] = '{
    {16'h0001, 16'h0000, 16'h0001},
    {16'h0001, 16'h0001, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0001, 16'h0000, 16'h0001},
    {16'h0100, 16'h0000, 16'h0101},
    {16'h0000, 16'h0001, 16'h0100},
    {16'h0000, 16'h0100, 16'h0000},
    {16'h0300, 16'h0000, 16'h0300},
    {16'h0100, 16'h0100, 16'h0200},
    {16'h0000, 16'h0000, 16'h0300},
    {16'h8001, 16'h0300, 16'h8001},
    {16'h8001, 16'hFFFF, 16'h0000}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] d, logic [1:0] be);
    wr_en = 1'b1; wr_data = d; byte_en = be; tick(); wr_en = 1'b0;
  endtask

  task automatic rd(logic rt, logic [1:0] be);
    rd_en = 1'b1; rd_rt = rt; byte_en = be; tick(); rd_en = 1'b0; rd_rt = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    check("R10 rd_data at reset", rd_data, 16'h0000);
    check("R10 irq at reset", {15'b0, irq}, 16'h0000);
    rst_n = 1'b1; tick();

    for (int i = 0; i < 12; i++) begin
      evt_in = VEC[i][47:32]; tick();
      wr(VEC[i][31:16], 2'b11);
      rd(1'b0, 2'b11);
      check($sformatf("R2/R3/R4 vector %0d", i), rd_data, VEC[i][15:0]);
    end

    evt_in = 16'h0000; tick();
    wr(16'hFFFF, 2'b11);

    evt_in = 16'hA5A5; rd(1'b1, 2'b11);
    check("R1 real-time view", rd_data, 16'hA5A5);
    rd(1'b0, 2'b11);
    check("R7 COW read keeps bits", rd_data, 16'hA5A5);
    rd(1'b0, 2'b11);
    check("R7 COW second read", rd_data, 16'hA5A5);
    wr(16'hFFFF, 2'b01);
    rd(1'b0, 2'b11);
    check("R7 lane-masked clear", rd_data, 16'hA500);
    wr(16'h0000, 2'b11);
    rd(1'b0, 2'b11);
    check("R7 zero write no effect", rd_data, 16'hA500);

    clr_wr = 1'b0;
    wr(16'hFFFF, 2'b11);
    rd(1'b0, 2'b01);
    check("R7/R5 COR ignores write, 16-bit read full word", rd_data, 16'hA500);
    rd(1'b0, 2'b11);
    check("R5 COR cleared all", rd_data, 16'h0000);

    evt_in = 16'h0000; tick();
    evt_in = 16'h00FF; tick();
    bus8 = 1'b1;
    rd(1'b0, 2'b01);
    check("R6 low lane read", rd_data, 16'h00FF);
    rd(1'b0, 2'b10);
    check("R6 high lane read", rd_data, 16'hA500);
    rd(1'b0, 2'b11);
    check("R6 both lanes cleared", rd_data, 16'h0000);
    bus8 = 1'b0;

    clr_wr = 1'b1;
    evt_in = 16'h01FF; wr(16'hFFFF, 2'b11);
    rd(1'b0, 2'b11);
    check("R8 set wins over clear", rd_data, 16'h0100);
    wr(16'h0100, 2'b11);

    evt_in = 16'h03FF; tick();
    tick();
    check("R9 masked bit no irq", {15'b0, irq}, 16'h0000);
    irq_en = 16'h0200; tick();
    check("R9 enabled bit raises irq", {15'b0, irq}, 16'h0001);
    irq_en = 16'h0100; tick();
    check("R9 other enable drops irq", {15'b0, irq}, 16'h0000);
    irq_en = 16'h0200; tick();
    wr(16'h0200, 2'b11);
    tick();
    check("R9 irq falls after clear", {15'b0, irq}, 16'h0000);
    irq_en = 16'h0000;

    rst_n = 1'b0; evt_in = 16'h0001; tick(); tick();
    check("R10 rd_data under reset", rd_data, 16'h0000);
    rst_n = 1'b1; tick();
    rd(1'b0, 2'b11);
    check("R10 event high at reset exit latches", rd_data, 16'h0001);

    finish_run();
  end
endmodule